// File: doc/BRIEF.md
# Ethernet Controller Control/Status Registers and Init-Block Loader

This block is the host-facing control logic of a descriptor-based Ethernet controller. The host reaches four 16-bit control/status registers through two ports. A select port picks the register. A data port reads or writes the register that is selected. Register zero is the command and status word. It mixes bits that a write of one clears, bits that a write can only set, and bits the host writes directly. Event pulses from the ring engines set its status bits. The block computes the two summary bits from the status bits and drives a registered interrupt line.

Setting the initialization command makes the block fetch twelve halfwords from a shared buffer RAM. The fetch starts at the byte address formed by registers two and one, and uses a one-cycle-latency read port. From these words the block keeps the operating mode, the station address, the multicast filter, and the base address and descriptor count of each ring. It presents these values to the transmit and receive ring engines, together with the ring enables, a transmit-demand flag and a ring-rewind pulse. While the fetch runs, host writes are held off through a ready signal.

Top module: `nic_csr_ctrl`

## Requirements
- R1: A write to the select port (host_addr=1) keeps only bits 1:0 of the data. A read of the select port returns those two bits, zero-extended. The data port (host_addr=0) reads or writes the selected register. Registers 1 to 3 are plain 16-bit storage with reset value zero.
- R2: Register 0 bits 14 (babble), 13 (collision), 12 (missed frame), 11 (memory error), 10 (rx done), 9 (tx done) and 8 (init done) clear when written with one and are unchanged when written with zero. evt_set[5:0] sets bits 14, 13, 12, 11, 10 and 9 in that order from bit 5 down. An event in the same cycle as a clearing write wins.
- R3: Register 0 bits 3 (tx demand), 1 (start) and 0 (init) are set by writing one and are never cleared by a write. Setting bit 1 or bit 0 clears bit 2 (stop). A tdmd_clr pulse clears bit 3. A write that sets bit 3 wins over tdmd_clr.
- R4: Writing one to bit 2 sets stop and clears start and init, even when start or init are written with one in the same word.
- R5: Bit 6 (interrupt enable) takes the written value on every register 0 write. After reset, register 0 reads 0x0004.
- R6: When init is set, the block reads twelve halfwords, one per clock, from consecutive halfword addresses. The first address is {reg2[7:0], reg1[15:0]} shifted right by one, so byte bit 0 is ignored. Read data is taken one cycle after its address. host_ready is low from the init write until init clears, and writes made while it is low are dropped.
- R7: Fetched words w0..w11 give the mode (w0), the station address {w3,w2,w1}, the filter {w7,w6,w5,w4}, the rx ring base {w9[7:0],w8} with 2^w9[15:13] descriptors, and the tx ring base {w11[7:0],w10} with 2^w11[15:13] descriptors.
- R8: On fetch completion, bit 4 (tx on) becomes the inverse of mode bit 1 and bit 5 (rx on) the inverse of mode bit 0. Init-done is set, init is cleared, and ring_rewind pulses for one cycle in the cycle these changes appear.
- R9: Bit 15 reads as the OR of bits 14, 13, 12 and 11. Bit 7 reads as the OR of bits 14, 12, 11, 10, 9 and 8.
- R10: irq is high exactly while bits 7 and 6 are both set.
- R11: A set memory-error bit forces tx on and rx on to zero, and a set stop bit forces init-done to zero. tx_on, rx_on and tx_demand mirror bits 4, 5 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 1 | 0 selects the data port, 1 the select port |
| host_wr | input | 1 | Host write strobe, taken only while host_ready is high |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the addressed port |
| host_ready | output | 1 | Low while an init-block fetch is pending |
| evt_set | input | 6 | Status event pulses from the ring engines |
| tdmd_clr | input | 1 | Transmit engine acknowledges the transmit demand |
| mem_rd_en | output | 1 | Buffer RAM read enable |
| mem_addr | output | 23 | Buffer RAM halfword address |
| mem_rdata | input | 16 | Buffer RAM read data, one cycle after the address |
| cfg_mode | output | 16 | Mode word |
| cfg_station | output | 48 | Station address |
| cfg_mcast | output | 64 | Multicast filter |
| rx_ring_base | output | 24 | Receive ring byte base address |
| rx_ring_count | output | 8 | Receive descriptor count |
| tx_ring_base | output | 24 | Transmit ring byte base address |
| tx_ring_count | output | 8 | Transmit descriptor count |
| ring_rewind | output | 1 | One-cycle pulse: ring indices return to zero |
| tx_on | output | 1 | Transmitter enabled |
| rx_on | output | 1 | Receiver enabled |
| tx_demand | output | 1 | Transmit demand pending |
| irq | output | 1 | Interrupt request |

## Verification
The hardest states to reach from the ports are the ones where several register-0 rules act in the same cycle. Examples are a memory error after the rings have been enabled by a fetch, a stop written while init-done is set, and a clearing write that meets the event it would clear. The stimulus first walks a table of register-0 writes and event pulses whose expected readbacks were worked out bit by bit. It then runs two complete init fetches from a bench RAM at different bases with different modes. One of these has an odd byte base and contains a write attempt while the block is not ready. After each fetch the bench checks the parsed fields, the read addresses, the rewind pulse and the resulting enables.

// File: rtl/nic_csr_pkg.sv
package nic_csr_pkg;
  localparam int DATA_W = 16;

  // register 0 bit positions (decoded by host software)
  localparam int B_SERR = 15;
  localparam int B_BABL = 14;
  localparam int B_CERR = 13;
  localparam int B_MISS = 12;
  localparam int B_MERR = 11;
  localparam int B_RINT = 10;
  localparam int B_TINT = 9;
  localparam int B_IDON = 8;
  localparam int B_INTR = 7;
  localparam int B_INEA = 6;
  localparam int B_RXON = 5;
  localparam int B_TXON = 4;
  localparam int B_TDMD = 3;
  localparam int B_STOP = 2;
  localparam int B_STRT = 1;
  localparam int B_INIT = 0;

  // event input positions
  localparam int EV_W    = 6;
  localparam int EV_BABL = 5;
  localparam int EV_CERR = 4;
  localparam int EV_MISS = 3;
  localparam int EV_MERR = 2;
  localparam int EV_RINT = 1;
  localparam int EV_TINT = 0;

  // initialization block layout, in halfwords
  localparam int IB_WORDS = 12;
  localparam int W_MODE   = 0;
  localparam int W_STA    = 1;
  localparam int W_FLT    = 4;
  localparam int W_RXLO   = 8;
  localparam int W_RXHI   = 9;
  localparam int W_TXLO   = 10;
  localparam int W_TXHI   = 11;

  // ring size code
  localparam int CODE_W   = 3;
  localparam int CODE_MSB = 15;
  localparam int CNT_W    = 1 << CODE_W;

  function automatic logic [CNT_W-1:0] ring_count(input logic [CODE_W-1:0] code);
    return CNT_W'(1) << code;
  endfunction
endpackage

// File: rtl/nic_host_regs.sv
module nic_host_regs
  import nic_csr_pkg::*;
#(
  parameter int NREGS  = 4,
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel_wr,
  input  logic                 data_wr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    csr0_val,
  output logic [DATA_W-1:0]    sel_rd,
  output logic [DATA_W-1:0]    data_rd,
  output logic                 csr0_wr,
  output logic [ADDR_W-2:0]    ib_hw_base
);
  localparam int SEL_W = $clog2(NREGS);
  localparam int HI_W  = ADDR_W - DATA_W;

  logic [SEL_W-1:0]  sel_q;
  logic [DATA_W-1:0] csr_q [1:NREGS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      for (int k = 1; k < NREGS; k++) csr_q[k] <= '0;
    end else begin
      if (sel_wr) sel_q <= wdata[SEL_W-1:0];
      for (int k = 1; k < NREGS; k++)
        if (data_wr && sel_q == SEL_W'(k)) csr_q[k] <= wdata;
    end
  end

  always_comb begin
    data_rd = csr0_val;
    for (int k = 1; k < NREGS; k++)
      if (sel_q == SEL_W'(k)) data_rd = csr_q[k];
  end

  assign sel_rd     = DATA_W'(sel_q);
  assign csr0_wr    = data_wr && (sel_q == '0);
  assign ib_hw_base = {csr_q[2][HI_W-1:0], csr_q[1][DATA_W-1:1]};

  generate
    for (genvar g = 1; g < NREGS; g++) begin : g_hold
      // R1: plain registers change only through a data write while selected
      a_r1_csr_hold: assert property (@(posedge clk) disable iff (rst)
        !(data_wr && sel_q == SEL_W'(g)) |=> $stable(csr_q[g]));
    end
  endgenerate
endmodule

// File: rtl/nic_init_fetch.sv
module nic_init_fetch
  import nic_csr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_req,
  input  logic [ADDR_W-2:0]    hw_base,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 mem_rd_en,
  output logic [ADDR_W-2:0]    mem_addr,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    mode,
  output logic [3*DATA_W-1:0]  station,
  output logic [4*DATA_W-1:0]  mcast,
  output logic [ADDR_W-1:0]    rx_base,
  output logic [CNT_W-1:0]     rx_cnt,
  output logic [ADDR_W-1:0]    tx_base,
  output logic [CNT_W-1:0]     tx_cnt
);
  localparam int IDX_W = $clog2(IB_WORDS);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(IB_WORDS - 1);

  logic [DATA_W-1:0] word_q [IB_WORDS];
  logic [IDX_W-1:0]  issue_cnt, cap_idx;
  logic              pend_q;
  logic              start;

  assign start = start_req && !busy && !done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_addr  <= '0;
      issue_cnt <= '0;
      cap_idx   <= '0;
      pend_q    <= 1'b0;
      for (int k = 0; k < IB_WORDS; k++) word_q[k] <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        mem_rd_en <= 1'b1;
        mem_addr  <= hw_base;
        issue_cnt <= '0;
        pend_q    <= 1'b0;
      end else if (busy) begin
        pend_q  <= mem_rd_en;
        cap_idx <= issue_cnt;
        if (mem_rd_en) begin
          issue_cnt <= issue_cnt + 1'b1;
          mem_addr  <= mem_addr + 1'b1;
          if (issue_cnt == LAST) mem_rd_en <= 1'b0;
        end
        if (pend_q) begin
          word_q[cap_idx] <= mem_rdata;
          if (cap_idx == LAST) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign mode    = word_q[W_MODE];
  assign station = {word_q[W_STA+2], word_q[W_STA+1], word_q[W_STA]};
  assign mcast   = {word_q[W_FLT+3], word_q[W_FLT+2], word_q[W_FLT+1], word_q[W_FLT]};
  assign rx_base = {word_q[W_RXHI][HI_W-1:0], word_q[W_RXLO]};
  assign tx_base = {word_q[W_TXHI][HI_W-1:0], word_q[W_TXLO]};
  assign rx_cnt  = ring_count(word_q[W_RXHI][CODE_MSB -: CODE_W]);
  assign tx_cnt  = ring_count(word_q[W_TXHI][CODE_MSB -: CODE_W]);

  // R6: reads only issued inside a fetch
  a_r6_read_in_fetch: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);
  // R6: back-to-back reads walk consecutive halfwords
  a_r6_consecutive: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + 1'b1));
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/nic_csr0_ctrl.sv
module nic_csr0_ctrl
  import nic_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] wd,
  input  logic [EV_W-1:0]   evt,
  input  logic              tdmd_clr,
  input  logic              init_done,
  input  logic [1:0]        done_mode,
  output logic [DATA_W-1:0] csr0,
  output logic              init_pend,
  output logic              tx_on,
  output logic              rx_on,
  output logic              tx_demand,
  output logic              irq,
  output logic              ring_rewind
);
  logic babl_q, cerr_q, miss_q, merr_q, rint_q, tint_q, idon_q;
  logic inea_q, rxon_q, txon_q, tdmd_q, stop_q, strt_q, init_q;
  logic babl_n, cerr_n, miss_n, merr_n, rint_n, tint_n, idon_n;
  logic inea_n, rxon_n, txon_n, tdmd_n, stop_n, strt_n, init_n;
  logic irq_q, rew_q;

  always_comb begin
    babl_n = evt[EV_BABL] | (babl_q & ~(wr & wd[B_BABL]));
    cerr_n = evt[EV_CERR] | (cerr_q & ~(wr & wd[B_CERR]));
    miss_n = evt[EV_MISS] | (miss_q & ~(wr & wd[B_MISS]));
    merr_n = evt[EV_MERR] | (merr_q & ~(wr & wd[B_MERR]));
    rint_n = evt[EV_RINT] | (rint_q & ~(wr & wd[B_RINT]));
    tint_n = evt[EV_TINT] | (tint_q & ~(wr & wd[B_TINT]));
    idon_n = init_done    | (idon_q & ~(wr & wd[B_IDON]));
    tdmd_n = (tdmd_q & ~tdmd_clr) | (wr & wd[B_TDMD]);
    inea_n = wr ? wd[B_INEA] : inea_q;
    strt_n = strt_q;
    init_n = init_q;
    stop_n = stop_q;
    if (wr) begin
      if (wd[B_STRT]) begin strt_n = 1'b1; stop_n = 1'b0; end
      if (wd[B_INIT]) begin init_n = 1'b1; stop_n = 1'b0; end
      if (wd[B_STOP]) begin stop_n = 1'b1; strt_n = 1'b0; init_n = 1'b0; end
    end
    txon_n = txon_q;
    rxon_n = rxon_q;
    if (init_done) begin
      init_n = 1'b0;
      txon_n = ~done_mode[1];
      rxon_n = ~done_mode[0];
    end
    if (merr_n) begin txon_n = 1'b0; rxon_n = 1'b0; end
    if (stop_n) idon_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {babl_q, cerr_q, miss_q, merr_q, rint_q, tint_q, idon_q} <= '0;
      {inea_q, rxon_q, txon_q, tdmd_q, strt_q, init_q} <= '0;
      stop_q <= 1'b1;
      irq_q  <= 1'b0;
      rew_q  <= 1'b0;
    end else begin
      babl_q <= babl_n; cerr_q <= cerr_n; miss_q <= miss_n; merr_q <= merr_n;
      rint_q <= rint_n; tint_q <= tint_n; idon_q <= idon_n;
      inea_q <= inea_n; rxon_q <= rxon_n; txon_q <= txon_n; tdmd_q <= tdmd_n;
      stop_q <= stop_n; strt_q <= strt_n; init_q <= init_n;
      irq_q  <= inea_n & (babl_n | miss_n | merr_n | rint_n | tint_n | idon_n);
      rew_q  <= init_done;
    end
  end

  always_comb begin
    csr0         = '0;
    csr0[B_SERR] = babl_q | cerr_q | miss_q | merr_q;
    csr0[B_BABL] = babl_q;
    csr0[B_CERR] = cerr_q;
    csr0[B_MISS] = miss_q;
    csr0[B_MERR] = merr_q;
    csr0[B_RINT] = rint_q;
    csr0[B_TINT] = tint_q;
    csr0[B_IDON] = idon_q;
    csr0[B_INTR] = babl_q | miss_q | merr_q | rint_q | tint_q | idon_q;
    csr0[B_INEA] = inea_q;
    csr0[B_RXON] = rxon_q;
    csr0[B_TXON] = txon_q;
    csr0[B_TDMD] = tdmd_q;
    csr0[B_STOP] = stop_q;
    csr0[B_STRT] = strt_q;
    csr0[B_INIT] = init_q;
  end

  assign init_pend   = init_q;
  assign tx_on       = txon_q;
  assign rx_on       = rxon_q;
  assign tx_demand   = tdmd_q;
  assign irq         = irq_q;
  assign ring_rewind = rew_q;

  // R4: stop dominates start and init
  a_r4_stop_wins: assert property (@(posedge clk) disable iff (rst)
    (wr && wd[B_STOP]) |=> (stop_q && !strt_q && !init_q));
  // R2: a clearing write without a competing event clears the bit
  a_r2_w1c_tint: assert property (@(posedge clk) disable iff (rst)
    (wr && wd[B_TINT] && !evt[EV_TINT]) |=> !tint_q);
  // R3: start survives any write that does not carry stop
  a_r3_strt_sticky: assert property (@(posedge clk) disable iff (rst)
    (strt_q && !(wr && wd[B_STOP])) |=> strt_q);
  // R11: memory error keeps both rings off
  a_r11_merr_off: assert property (@(posedge clk) disable iff (rst)
    merr_q |-> (!txon_q && !rxon_q));
  // R11: stop keeps init-done clear
  a_r11_stop_idon: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> !idon_q);
  // R10: no interrupt without the enable
  a_r10_irq_enable: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> inea_q);
endmodule

// File: rtl/nic_csr_ctrl.sv
module nic_csr_ctrl
  import nic_csr_pkg::*;
#(
  parameter int NREGS  = 4,
  parameter int ADDR_W = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 host_addr,
  input  logic                 host_wr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  output logic                 host_ready,
  input  logic [EV_W-1:0]      evt_set,
  input  logic                 tdmd_clr,
  output logic                 mem_rd_en,
  output logic [ADDR_W-2:0]    mem_addr,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic [DATA_W-1:0]    cfg_mode,
  output logic [3*DATA_W-1:0]  cfg_station,
  output logic [4*DATA_W-1:0]  cfg_mcast,
  output logic [ADDR_W-1:0]    rx_ring_base,
  output logic [CNT_W-1:0]     rx_ring_count,
  output logic [ADDR_W-1:0]    tx_ring_base,
  output logic [CNT_W-1:0]     tx_ring_count,
  output logic                 ring_rewind,
  output logic                 tx_on,
  output logic                 rx_on,
  output logic                 tx_demand,
  output logic                 irq
);
  logic              wr_ok, csr0_wr, init_pend, busy, done;
  logic [DATA_W-1:0] csr0_val, sel_rd, data_rd;
  logic [ADDR_W-2:0] ib_hw_base;

  assign host_ready = !(init_pend || busy);
  assign wr_ok      = host_wr && host_ready;
  assign host_rdata = host_addr ? sel_rd : data_rd;

  nic_host_regs #(.NREGS(NREGS), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst),
    .sel_wr(wr_ok && host_addr), .data_wr(wr_ok && !host_addr),
    .wdata(host_wdata), .csr0_val(csr0_val),
    .sel_rd(sel_rd), .data_rd(data_rd), .csr0_wr(csr0_wr),
    .ib_hw_base(ib_hw_base)
  );

  nic_csr0_ctrl csr0_i (
    .clk(clk), .rst(rst), .wr(csr0_wr), .wd(host_wdata),
    .evt(evt_set), .tdmd_clr(tdmd_clr),
    .init_done(done), .done_mode(cfg_mode[1:0]),
    .csr0(csr0_val), .init_pend(init_pend),
    .tx_on(tx_on), .rx_on(rx_on), .tx_demand(tx_demand),
    .irq(irq), .ring_rewind(ring_rewind)
  );

  nic_init_fetch #(.ADDR_W(ADDR_W)) fetch_i (
    .clk(clk), .rst(rst), .start_req(init_pend), .hw_base(ib_hw_base),
    .mem_rdata(mem_rdata), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
    .busy(busy), .done(done),
    .mode(cfg_mode), .station(cfg_station), .mcast(cfg_mcast),
    .rx_base(rx_ring_base), .rx_cnt(rx_ring_count),
    .tx_base(tx_ring_base), .tx_cnt(tx_ring_count)
  );

  // R6: no register write lands while a fetch is pending
  a_r6_write_blocked: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr && !host_addr) |=> $stable(csr0_val[B_STOP]));
endmodule

// File: tb/nic_csr_ctrl_tb.sv
`timescale 1ns/1ps
module nic_csr_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_addr, host_wr;
  logic [15:0] host_wdata, host_rdata;
  logic        host_ready;
  logic [5:0]  evt_set;
  logic        tdmd_clr;
  logic        mem_rd_en;
  logic [22:0] mem_addr;
  logic [15:0] mem_rdata;
  logic [15:0] cfg_mode;
  logic [47:0] cfg_station;
  logic [63:0] cfg_mcast;
  logic [23:0] rx_ring_base, tx_ring_base;
  logic [7:0]  rx_ring_count, tx_ring_count;
  logic        ring_rewind, tx_on, rx_on, tx_demand, irq;

  always #2 clk = ~clk;

  nic_csr_ctrl dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .evt_set(evt_set), .tdmd_clr(tdmd_clr),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cfg_mode(cfg_mode), .cfg_station(cfg_station), .cfg_mcast(cfg_mcast),
    .rx_ring_base(rx_ring_base), .rx_ring_count(rx_ring_count),
    .tx_ring_base(tx_ring_base), .tx_ring_count(tx_ring_count),
    .ring_rewind(ring_rewind), .tx_on(tx_on), .rx_on(rx_on),
    .tx_demand(tx_demand), .irq(irq)
  );

  // bench buffer RAM, one-cycle read latency
  logic [15:0] ram [64];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= ram[mem_addr[5:0]];

  int          checks = 0, failures = 0;
  int          rd_cnt = 0, addr_err = 0, rewind_cnt = 0;
  logic [22:0] first_addr, last_addr;
  bit          finished = 0;

  always @(negedge clk) begin
    if (ring_rewind) rewind_cnt++;
    if (mem_rd_en) begin
      if (rd_cnt == 0) first_addr = mem_addr;
      else if (mem_addr != last_addr + 23'd1) addr_err++;
      last_addr = mem_addr;
      rd_cnt++;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic hwrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_addr = 1'b0;
  endtask

  task automatic hread(input logic a, output logic [15:0] v);
    host_addr = a;
    #1;
    v = host_rdata;
    host_addr = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!host_ready && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  // {wr, wdata, evt, expected reg0, expected irq}
  localparam int NV = 13;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0, 16'h0000, 6'b000001, 16'h0284, 1'b0}, // R2 event sets tx done, R9 summary
    {1'b1, 16'h0040, 6'b000000, 16'h02C4, 1'b1}, // R5 enable, zero writes keep R2 bits, R10
    {1'b0, 16'h0000, 6'b110000, 16'hE2C4, 1'b1}, // R9 error summary
    {1'b1, 16'h6040, 6'b000000, 16'h02C4, 1'b1}, // R2 write-one clears
    {1'b1, 16'h0240, 6'b000000, 16'h0044, 1'b0}, // R2 clear tx done, R10 drops
    {1'b1, 16'h000A, 6'b000000, 16'h000A, 1'b0}, // R3 set demand+start clears stop, R5 enable off
    {1'b1, 16'h0000, 6'b000000, 16'h000A, 1'b0}, // R3 zero write keeps set-only bits
    {1'b0, 16'h0000, 6'b000100, 16'h888A, 1'b0}, // R2 memory error event
    {1'b1, 16'h0800, 6'b000100, 16'h888A, 1'b0}, // R2 event beats clear
    {1'b1, 16'h0800, 6'b000000, 16'h000A, 1'b0}, // R2 clear memory error
    {1'b1, 16'h0007, 6'b000000, 16'h000C, 1'b0}, // R4 stop wins
    {1'b0, 16'h0000, 6'b001010, 16'h948C, 1'b0}, // R9 miss + rx done
    {1'b1, 16'h1440, 6'b000000, 16'h004C, 1'b0}  // R2 clears, R5 enable on
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [39:0] vec;
    int n;
    rst = 1'b1; host_addr = 1'b0; host_wr = 1'b0; host_wdata = '0;
    evt_set = '0; tdmd_clr = 1'b0;
    for (int i = 0; i < 64; i++) ram[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    hread(1'b0, v); chk("R5", "reg0 after reset", v, 16'h0004);
    hread(1'b1, v); chk("R1", "select after reset", v, 16'h0000);
    chk("R6", "ready after reset", host_ready, 1'b1);
    chk("R10", "irq after reset", irq, 1'b0);

    // table walk over register 0
    for (int i = 0; i < NV; i++) begin
      vec = VEC[i];
      @(negedge clk);
      host_addr = 1'b0; host_wr = vec[39]; host_wdata = vec[38:23]; evt_set = vec[22:17];
      @(negedge clk);
      host_wr = 1'b0; evt_set = '0;
      hread(1'b0, v);
      chk("R2,R3,R4,R5,R9", $sformatf("reg0 vector %0d", i), v, vec[16:1]);
      chk("R10", $sformatf("irq vector %0d", i), irq, vec[0]);
    end

    // transmit demand acknowledge
    chk("R11", "tx_demand mirrors bit 3", tx_demand, 1'b1);
    @(negedge clk); tdmd_clr = 1'b1;
    @(negedge clk); tdmd_clr = 1'b0;
    hread(1'b0, v); chk("R3", "tdmd_clr clears demand", v, 16'h0044);
    chk("R11", "tx_demand after clear", tx_demand, 1'b0);

    // select and plain registers
    hwrite(1'b1, 16'h0007);
    hread(1'b1, v); chk("R1", "select keeps two bits", v, 16'h0003);
    hwrite(1'b0, 16'hBEEF);
    hread(1'b0, v); chk("R1", "reg3 readback", v, 16'hBEEF);
    hwrite(1'b1, 16'h0001); hwrite(1'b0, 16'h0021);
    hwrite(1'b1, 16'h0002); hwrite(1'b0, 16'h0000);
    hwrite(1'b1, 16'h0001);
    hread(1'b0, v); chk("R1", "reg1 readback", v, 16'h0021);
    hwrite(1'b1, 16'h0000);

    // first init block at byte 0x21 (bit 0 ignored -> halfword 0x10)
    ram[16] = 16'h0002;
    ram[17] = 16'h1111; ram[18] = 16'h2222; ram[19] = 16'h3333;
    ram[20] = 16'hA0A0; ram[21] = 16'hB1B1; ram[22] = 16'hC2C2; ram[23] = 16'hD3D3;
    ram[24] = 16'h4560; ram[25] = 16'h6012; ram[26] = 16'h7780; ram[27] = 16'hE0AB;
    rd_cnt = 0; addr_err = 0; rewind_cnt = 0;
    hwrite(1'b0, 16'h0041);
    chk("R6", "ready low during fetch", host_ready, 1'b0);
    hwrite(1'b0, 16'h0004);  // must be dropped
    wait_ready(n);
    chk("R6", "fetch finished", host_ready, 1'b1);
    chk("R6", "read count", 64'(rd_cnt), 64'd12);
    chk("R6", "first read address", first_addr, 23'h000010);
    chk("R6", "consecutive addresses", 64'(addr_err), 64'd0);
    hread(1'b0, v); chk("R8", "reg0 after fetch, blocked stop dropped", v, 16'h01E0);
    chk("R8", "rewind pulses", 64'(rewind_cnt), 64'd1);
    chk("R7", "mode", cfg_mode, 16'h0002);
    chk("R7", "station", cfg_station, 48'h333322221111);
    chk("R7", "filter", cfg_mcast, 64'hD3D3C2C2B1B1A0A0);
    chk("R7", "rx base", rx_ring_base, 24'h124560);
    chk("R7", "rx count", rx_ring_count, 8'd8);
    chk("R7", "tx base", tx_ring_base, 24'hAB7780);
    chk("R7", "tx count max", tx_ring_count, 8'd128);
    chk("R8", "tx off by mode", tx_on, 1'b0);
    chk("R8", "rx on by mode", rx_on, 1'b1);
    chk("R10", "irq from init done", irq, 1'b1);

    // memory error and stop forcing
    @(negedge clk); evt_set = 6'b000100;
    @(negedge clk); evt_set = '0;
    hread(1'b0, v); chk("R11", "memory error drops ring enables", v, 16'h89C0);
    chk("R11", "rx_on forced off", rx_on, 1'b0);
    hwrite(1'b0, 16'h0004);
    hread(1'b0, v); chk("R11", "stop clears init done", v, 16'h8884);
    hwrite(1'b0, 16'h0804);
    hread(1'b0, v); chk("R2", "memory error cleared", v, 16'h0004);

    // second init block at byte 0x030040 -> halfword 0x018020, mode 0
    ram[32] = 16'h0000;
    ram[33] = 16'hCAFE; ram[34] = 16'hBEEF; ram[35] = 16'h0123;
    ram[36] = 16'hFFFF; ram[37] = 16'hFFFF; ram[38] = 16'hFFFF; ram[39] = 16'hFFFF;
    ram[40] = 16'h0100; ram[41] = 16'h0000; ram[42] = 16'h0200; ram[43] = 16'h2005;
    hwrite(1'b1, 16'h0001); hwrite(1'b0, 16'h0040);
    hwrite(1'b1, 16'h0002); hwrite(1'b0, 16'h0003);
    hwrite(1'b1, 16'h0000);
    rd_cnt = 0; addr_err = 0; rewind_cnt = 0;
    hwrite(1'b0, 16'h0001);
    wait_ready(n);
    chk("R6", "second first address", first_addr, 23'h018020);
    chk("R6", "second read count", 64'(rd_cnt), 64'd12);
    hread(1'b0, v); chk("R8", "both rings on", v, 16'h01B0);
    chk("R10", "irq masked", irq, 1'b0);
    chk("R7", "station 2", cfg_station, 48'h0123BEEFCAFE);
    chk("R7", "rx count min", rx_ring_count, 8'd1);
    chk("R7", "tx base 2", tx_ring_base, 24'h050200);
    chk("R7", "tx count 2", tx_ring_count, 8'd2);
    chk("R8", "rewind once", 64'(rewind_cnt), 64'd1);
    chk("R11", "tx_on mirrors", tx_on, 1'b1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule